// File: doc/BRIEF.md
# DDR Write Burst Controller with Byte Masking

This block sits on the controller side of a double-data-rate memory interface and carries out one write burst per accepted request. A request names a bank, a starting column, an auto-precharge choice and a burst length. The block places a single write command on the command pins. It then sends the data as two beats per clock, each beat with one mask bit per byte lane. It also drives the data strobe, including the low preamble before the first beat and the low postamble after the last one.

Data words arrive on a valid/ready channel, and each word holds the two beats of one clock. The outputs are registered pairs: one value for the first half of the clock and one for the second. A double-data-rate output cell at the pad turns each pair into edge-rate signals. A word that is not ready in its slot does not stall the burst. That slot goes out fully masked, so no byte of it is written.

Top module: `wburst_ctl`

## Requirements
- R1: The clock after a request is accepted shows the write command on the command pins as {csN,rasN,casN,weN} = 4'b0100, for exactly one clock. Every other clock shows all four pins high.
- R2: In the command clock, bankOut carries the request bank and addrOut[8:0] carries the start column. addrOut[10] carries the auto-precharge flag, and every other address bit is 0.
- R3: In the command clock the strobe is driven only in the second half, at a low level: dqsOe = 2'b10 and dqsOut = 2'b00. Bit 0 is the first half-clock and bit 1 is the second.
- R4: The clocks that immediately follow the command are the data clocks. Their number is half the burst length, where burst code 0 gives 2 beats, code 1 gives 4, and codes 2 and 3 give 8. In each data clock dqOe = 1, dqsOe = 2'b11 and dqsOut = 2'b01.
- R5: In the clock after the last data clock, the strobe is driven low in the first half only (dqsOe = 2'b01, dqsOut = 2'b00). In the clock after that, dqsOe = 2'b00.
- R6: wdReady is high in the command clock and in every data clock except the last. A word taken at a clock edge appears on dqOut in the next clock. wdData[15:0] is the first beat (dqOut[15:0]) and wdData[31:16] is the second beat.
- R7: dmOut carries wdMask with the same layout. Bit 0 is the first beat's byte [7:0], bit 1 is the first beat's byte [15:8], and bits 3:2 are the same two lanes for the second beat. A mask bit of 1 blocks the write of that byte.
- R8: If wdValid is low while wdReady is high, the data clock that follows has dmOut = 4'hF.
- R9: Outside the data clocks, dqOe is 0 and dmOut is 4'hF. In those clocks wdValid and wdData have no effect on any output.
- R10: reqReady is high only when no burst is in progress. The earliest next request is accepted in the clock after the postamble clock.
- R11: During and right after reset, csN = 1, dqOe = 0, dqsOe = 2'b00, wdReady = 0 and reqReady = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Controller can take a request |
| reqBank | input | 2 | Target bank |
| reqCol | input | 9 | Starting column |
| reqAutoPre | input | 1 | Close the row after the burst |
| reqBurst | input | 2 | Burst length code |
| wdValid | input | 1 | Data word present |
| wdReady | output | 1 | Data word taken at the next edge |
| wdData | input | 32 | Two beats, first beat in the low half |
| wdMask | input | 4 | Byte masks for the two beats, 1 blocks |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| bankOut | output | 2 | Bank address |
| addrOut | output | 13 | Address lines |
| dqOut | output | 32 | Beat pair for this clock |
| dqOe | output | 1 | Data bus driven |
| dmOut | output | 4 | Mask pair for this clock |
| dqsOut | output | 2 | Strobe level per half-clock |
| dqsOe | output | 2 | Strobe driven per half-clock |

## Verification
The hardest case is a data word that is missing in the middle of a burst. The upstream source must drop wdValid in exactly the clock where wdReady is high for that slot. Otherwise nothing can be seen at the pins. The bench picks the missing slot arithmetically for every fifth transfer, so that over the sweep it falls on the first slot, on middle slots and on the last slot. A memory model fed from the pins must then show the bytes of that slot unchanged. Back-to-back requests are issued at the earliest clock that reqReady allows, so that the postamble of one burst is checked against the preamble of the next.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int MAX_BURST = 8;
  localparam int CNT_W = $clog2(MAX_BURST / 2 + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DATA, PH_POST} phase_t;

  // Describes what the next clock's outputs must be.
  typedef struct packed {
    logic issueCmd;
    logic driveData;
    logic driveTail;
  } wb_strobe_t;

  // Data clocks per burst: two beats per clock.
  function automatic logic [CNT_W-1:0] cyclesFor(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      default: return CNT_W'(MAX_BURST / 2);
    endcase
  endfunction
endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqBurst,
  output logic       reqReady,
  output logic       wdReady,
  output wb_strobe_t strobe
);
  phase_t phase, phaseNext;
  logic [CNT_W-1:0] left, leftNext;

  always_comb begin
    phaseNext = phase;
    leftNext  = left;
    strobe    = '0;
    case (phase)
      PH_IDLE: if (reqValid) begin
        phaseNext       = PH_CMD;
        leftNext        = cyclesFor(reqBurst);
        strobe.issueCmd = 1'b1;
      end
      PH_CMD: begin
        phaseNext        = PH_DATA;
        strobe.driveData = 1'b1;
      end
      PH_DATA: if (left == CNT_W'(1)) begin
        phaseNext        = PH_POST;
        strobe.driveTail = 1'b1;
      end else begin
        leftNext         = left - CNT_W'(1);
        strobe.driveData = 1'b1;
      end
      PH_POST: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      left  <= '0;
    end else begin
      phase <= phaseNext;
      left  <= leftNext;
    end
  end

  assign reqReady = (phase == PH_IDLE);
  assign wdReady  = strobe.driveData;
endmodule

// File: rtl/wb_datapath.sv
module wb_datapath
  import wb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wb_strobe_t            strobe,
  input  logic [BANK_W-1:0]     reqBank,
  input  logic [COL_W-1:0]      reqCol,
  input  logic                  reqAutoPre,
  input  logic                  wdValid,
  input  logic [2*DATA_W-1:0]   wdData,
  input  logic [2*DATA_W/8-1:0] wdMask,
  output logic                  csN,
  output logic                  rasN,
  output logic                  casN,
  output logic                  weN,
  output logic [BANK_W-1:0]     bankOut,
  output logic [ADDR_W-1:0]     addrOut,
  output logic [2*DATA_W-1:0]   dqOut,
  output logic                  dqOe,
  output logic [2*DATA_W/8-1:0] dmOut,
  output logic [1:0]            dqsOut,
  output logic [1:0]            dqsOe
);
  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] cmdAddr;

  always_comb begin
    cmdAddr         = ADDR_W'(reqCol);
    cmdAddr[AP_BIT] = reqAutoPre;
  end

  // Command pins and address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {csN, rasN, casN, weN} <= 4'b1111;
      bankOut <= '0;
      addrOut <= '0;
    end else if (strobe.issueCmd) begin
      {csN, rasN, casN, weN} <= 4'b0100;
      bankOut <= reqBank;
      addrOut <= cmdAddr;
    end else begin
      {csN, rasN, casN, weN} <= 4'b1111;
      bankOut <= '0;
      addrOut <= '0;
    end
  end

  // Strobe shape per half-clock: preamble, data toggling, postamble
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqsOe  <= 2'b00;
      dqsOut <= 2'b00;
      dqOe   <= 1'b0;
    end else begin
      dqOe <= strobe.driveData;
      if (strobe.issueCmd) begin
        dqsOe  <= 2'b10;
        dqsOut <= 2'b00;
      end else if (strobe.driveData) begin
        dqsOe  <= 2'b11;
        dqsOut <= 2'b01;
      end else if (strobe.driveTail) begin
        dqsOe  <= 2'b01;
        dqsOut <= 2'b00;
      end else begin
        dqsOe  <= 2'b00;
        dqsOut <= 2'b00;
      end
    end
  end

  // One register slice per beat and byte lane
  for (genvar b = 0; b < 2; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int IDX = b * LANES + l;
      logic takeByte;
      assign takeByte = strobe.driveData && wdValid;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dqOut[IDX*8 +: 8] <= '0;
          dmOut[IDX]        <= 1'b1;
        end else if (takeByte) begin
          dqOut[IDX*8 +: 8] <= wdData[IDX*8 +: 8];
          dmOut[IDX]        <= wdMask[IDX];
        end else begin
          dqOut[IDX*8 +: 8] <= '0;
          dmOut[IDX]        <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wburst_ctl.sv
module wburst_ctl
  import wb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [BANK_W-1:0]     reqBank,
  input  logic [COL_W-1:0]      reqCol,
  input  logic                  reqAutoPre,
  input  logic [1:0]            reqBurst,
  input  logic                  wdValid,
  output logic                  wdReady,
  input  logic [2*DATA_W-1:0]   wdData,
  input  logic [2*DATA_W/8-1:0] wdMask,
  output logic                  csN,
  output logic                  rasN,
  output logic                  casN,
  output logic                  weN,
  output logic [BANK_W-1:0]     bankOut,
  output logic [ADDR_W-1:0]     addrOut,
  output logic [2*DATA_W-1:0]   dqOut,
  output logic                  dqOe,
  output logic [2*DATA_W/8-1:0] dmOut,
  output logic [1:0]            dqsOut,
  output logic [1:0]            dqsOe
);
  wb_strobe_t strobe;

  wb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBurst(reqBurst),
    .reqReady(reqReady), .wdReady(wdReady), .strobe(strobe)
  );

  wb_datapath #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqBank(reqBank), .reqCol(reqCol), .reqAutoPre(reqAutoPre),
    .wdValid(wdValid), .wdData(wdData), .wdMask(wdMask),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankOut(bankOut), .addrOut(addrOut),
    .dqOut(dqOut), .dqOe(dqOe), .dmOut(dmOut),
    .dqsOut(dqsOut), .dqsOe(dqsOe)
  );
endmodule

// File: rtl/wb_checker.sv
module wb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        wdValid,
  input logic        wdReady,
  input logic        csN,
  input logic        rasN,
  input logic        casN,
  input logic        weN,
  input logic        dqOe,
  input logic [3:0]  dmOut,
  input logic [1:0]  dqsOut,
  input logic [1:0]  dqsOe
);
  a_r1_write_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ({csN, rasN, casN, weN} == 4'b0100));

  a_r1_single_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> csN);

  a_r3_preamble: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> (dqsOe == 2'b10 && dqsOut == 2'b00 && !dqOe));

  a_r4_data_strobe: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (dqsOe == 2'b11 && dqsOut == 2'b01));

  a_r5_postamble: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqOe) |-> (dqsOe == 2'b01 && dqsOut == 2'b00));

  a_r6_ready_feeds_data: assert property (@(posedge clk) disable iff (!rstN)
    wdReady |=> dqOe);

  a_r8_underrun_masked: assert property (@(posedge clk) disable iff (!rstN)
    (wdReady && !wdValid) |=> (dmOut == 4'hF));

  a_r9_idle_masked: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dmOut == 4'hF));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!wdReady && !dqOe && dqsOe != 2'b11));
endmodule

bind wburst_ctl wb_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .wdValid(wdValid), .wdReady(wdReady),
  .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .dqOe(dqOe), .dmOut(dmOut), .dqsOut(dqsOut), .dqsOe(dqsOe)
);

// File: tb/test_wburst_ctl.sv
module test_wburst_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqBank = '0;
  logic [8:0]  reqCol = '0;
  logic        reqAutoPre = 1'b0;
  logic [1:0]  reqBurst = '0;
  logic        wdValid = 1'b0;
  logic        wdReady;
  logic [31:0] wdData = '0;
  logic [3:0]  wdMask = '0;
  logic        csN, rasN, casN, weN;
  logic [1:0]  bankOut;
  logic [12:0] addrOut;
  logic [31:0] dqOut;
  logic        dqOe;
  logic [3:0]  dmOut;
  logic [1:0]  dqsOut;
  logic [1:0]  dqsOe;

  int checks = 0;
  int errors = 0;
  int txn = 0;
  logic [15:0] memOut [0:2047];
  logic [15:0] memExp [0:2047];

  always #5 clk = ~clk;

  wburst_ctl i_wburst_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqCol(reqCol), .reqAutoPre(reqAutoPre),
    .reqBurst(reqBurst), .wdValid(wdValid), .wdReady(wdReady),
    .wdData(wdData), .wdMask(wdMask),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankOut(bankOut), .addrOut(addrOut), .dqOut(dqOut), .dqOe(dqOe),
    .dmOut(dmOut), .dqsOut(dqsOut), .dqsOe(dqsOe)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] beatVal(input int t, input int b);
    return 16'(t * 16'h1357 + b * 16'h0101 + 16'h00A5);
  endfunction

  function automatic logic [31:0] wordVal(input int t, input int k);
    return {beatVal(t, 2 * k + 1), beatVal(t, 2 * k)};
  endfunction

  function automatic logic [3:0] maskVal(input int t, input int k);
    return 4'((t + 3 * k) % 16);
  endfunction

  // Writes one beat into the pin-side memory model and the expected memory.
  task automatic applyBeat(input int bank, input int col, input int b,
                           input logic [15:0] pinData, input logic [1:0] pinMask,
                           input bit valid, input logic [15:0] expData,
                           input logic [1:0] expMask);
    int idx = bank * 512 + ((col + b) & 511);
    for (int l = 0; l < 2; l++) begin
      if (!pinMask[l]) memOut[idx][l*8 +: 8] = pinData[l*8 +: 8];
      if (valid && !expMask[l]) memExp[idx][l*8 +: 8] = expData[l*8 +: 8];
    end
    check(memOut[idx] === memExp[idx], "R7 masked memory", 32'(memOut[idx]),
          32'(memExp[idx]));
  endtask

  // Entered at a falling edge with the controller idle.
  task automatic doBurst(input int bank, input int col, input bit ap,
                         input int code, input int skipSlot);
    int n = (code == 0) ? 1 : (code == 1) ? 2 : 4;
    logic [12:0] expAddr;
    txn++;
    expAddr = 13'(col) | (ap ? 13'h400 : 13'h000);
    check(reqReady === 1'b1, "R10 ready before request", 32'(reqReady), 1);
    reqValid = 1'b1; reqBank = 2'(bank); reqCol = 9'(col);
    reqAutoPre = ap; reqBurst = 2'(code);
    @(negedge clk);
    reqValid = 1'b0;
    check({csN, rasN, casN, weN} === 4'b0100, "R1 write command",
          32'({csN, rasN, casN, weN}), 32'h4);
    check(bankOut === 2'(bank), "R2 bank", 32'(bankOut), 32'(bank));
    check(addrOut === expAddr, "R2 address", 32'(addrOut), 32'(expAddr));
    check(dqsOe === 2'b10 && dqsOut === 2'b00 && dqOe === 1'b0, "R3 preamble",
          32'({dqOe, dqsOe, dqsOut}), 32'h08);
    check(wdReady === 1'b1, "R6 ready in command clock", 32'(wdReady), 1);
    check(reqReady === 1'b0, "R10 busy", 32'(reqReady), 0);
    wdValid = (skipSlot != 0); wdData = wordVal(txn, 0); wdMask = maskVal(txn, 0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check({csN, rasN, casN, weN} === 4'b1111, "R1 no command in data",
            32'({csN, rasN, casN, weN}), 32'hF);
      check(dqOe === 1'b1 && dqsOe === 2'b11 && dqsOut === 2'b01, "R4 data clock",
            32'({dqOe, dqsOe, dqsOut}), 32'h1D);
      if (k != skipSlot) begin
        check(dqOut === wordVal(txn, k), "R6 beat data", dqOut, wordVal(txn, k));
        check(dmOut === maskVal(txn, k), "R7 beat mask", 32'(dmOut),
              32'(maskVal(txn, k)));
      end else begin
        check(dmOut === 4'hF, "R8 underrun slot masked", 32'(dmOut), 32'hF);
      end
      applyBeat(bank, col, 2 * k, dqOut[15:0], dmOut[1:0], k != skipSlot,
                wordVal(txn, k) >> 0, maskVal(txn, k));
      applyBeat(bank, col, 2 * k + 1, dqOut[31:16], dmOut[3:2], k != skipSlot,
                16'(wordVal(txn, k) >> 16), 2'(maskVal(txn, k) >> 2));
      check(wdReady === (k < n - 1), "R6 ready window", 32'(wdReady),
            32'(k < n - 1));
      if (k < n - 1) begin
        wdValid = (k + 1 != skipSlot);
        wdData = wordVal(txn, k + 1);
        wdMask = maskVal(txn, k + 1);
      end else begin
        wdValid = 1'b1; wdData = 32'hDEADBEEF; wdMask = 4'h0;
      end
    end
    @(negedge clk);
    check(dqsOe === 2'b01 && dqsOut === 2'b00, "R5 postamble",
          32'({dqsOe, dqsOut}), 32'h4);
    check(dqOe === 1'b0 && dmOut === 4'hF, "R9 tail not driven",
          32'({dqOe, dmOut}), 32'h0F);
    check(reqReady === 1'b0, "R10 busy in postamble", 32'(reqReady), 0);
    @(negedge clk);
    check(dqsOe === 2'b00, "R5 strobe released", 32'(dqsOe), 0);
    check(dqOe === 1'b0 && dmOut === 4'hF, "R9 idle not driven",
          32'({dqOe, dmOut}), 32'h0F);
    wdValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      memOut[i] = '0;
      memExp[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && dqOe === 1'b0 && dqsOe === 2'b00, "R11 reset outputs",
          32'({csN, dqOe, dqsOe}), 32'h8);
    check(reqReady === 1'b1 && wdReady === 1'b0, "R11 reset handshake",
          32'({reqReady, wdReady}), 32'h2);
    rstN = 1'b1;
    @(negedge clk);
    check(csN === 1'b1 && reqReady === 1'b1, "R11 after reset",
          32'({csN, reqReady}), 32'h3);

    // Idle data must be ignored
    for (int j = 0; j < 4; j++) begin
      wdValid = 1'b1; wdData = 32'h1234_0000 + 32'(j); wdMask = 4'h0;
      @(negedge clk);
      check(dqOe === 1'b0 && dmOut === 4'hF && dqOut === 32'h0 && wdReady === 1'b0,
            "R9 idle input ignored", dqOut, 0);
    end
    wdValid = 1'b0;

    for (int code = 0; code < 4; code++)
      for (int bank = 0; bank < 4; bank++)
        for (int ap = 0; ap < 2; ap++)
          for (int ci = 0; ci < 4; ci++) begin
            int col = (ci == 0) ? 0 : (ci == 1) ? 5 : (ci == 2) ? 500 : 511;
            int n = (code == 0) ? 1 : (code == 1) ? 2 : 4;
            int skip = ((txn + 1) % 5 == 0) ? (((txn + 1) / 5) % n) : -1;
            doBurst(bank, col, ap[0], code, skip);
          end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule